// File: doc/BRIEF.md
# Fully Associative Lookup Cache with Parallel Tag Match

This block is a small fully associative read cache. Each entry pairs an address tag, held in a content-addressable store, with a data word held in a parallel storage array. When a request arrives, its address is compared against every valid tag in the same cycle. The index of the matching row drives the read of the data array directly. A hit returns the stored word one cycle later.

On a miss, the block fetches the word from a slower backing memory through a request/acknowledge handshake. It installs the word in a victim entry and then returns it. The victim is the lowest-numbered empty entry while any entry is empty. Once every entry holds data, a rotating pointer picks the victim.

The block accepts one request at a time. A client waits for `done`, or watches `busy`, before it issues the next request.

Top module: `fa_cache`

## Requirements
- R1: After reset all entries are invalid, and `busy`, `done`, `hit` and `mem_req` are low. The first request after reset is therefore a miss.
- R2: A request whose address matches a valid tag is a hit. In the cycle after the request is accepted, `done` and `hit` are high and `rd_data` holds the word stored with that tag.
- R3: A request whose address matches no valid tag is a miss. From the cycle after acceptance, `mem_req` is high and `mem_addr` equals the request address. Both hold unchanged until `mem_ack` is sampled high.
- R4: In the cycle after `mem_ack` is sampled high, `done` is high, `hit` is low and `rd_data` equals the `mem_data` value sampled with the acknowledge. The entry is installed, so a later request to the same address hits and returns that word.
- R5: While an empty entry exists, a fill goes to the lowest-numbered empty entry. After reset, the first 16 distinct misses fill all 16 entries without displacing one another.
- R6: When all entries are valid, the victim is chosen by a rotating pointer. The pointer starts at entry 0 after reset and advances by one, wrapping, after every fill. Its effect is visible at the ports: the address evicted by the fill becomes a miss, and the other entries keep hitting.
- R7: `busy` is high from the cycle after a miss is accepted through the cycle in which `mem_ack` is sampled. A request raised while `busy` is high is ignored: it does not change `mem_addr` and installs nothing.
- R8: `done` is a single-cycle pulse per accepted request, and `hit` is high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe; taken only while `busy` is low |
| req_addr | input | 32 | Request address |
| busy | output | 1 | A miss fill is in progress |
| done | output | 1 | One-cycle pulse when `rd_data` holds the result |
| hit | output | 1 | With `done`: the result came from the cache |
| rd_data | output | 32 | Returned data word |
| mem_req | output | 1 | Fetch request to backing memory |
| mem_addr | output | 32 | Fetch address, held while `mem_req` is high |
| mem_ack | input | 1 | Backing memory has placed the word on `mem_data` |
| mem_data | input | 32 | Word returned by backing memory |

## Verification
Several kinds of internal fault show up at the ports:
- A corrupted valid bit or tag turns an expected hit into a miss. This is visible one cycle after acceptance, as `mem_req` rising instead of `done`.
- A wrong matching index, or a wrong fill row, returns another entry's word on the very next `done`.
- A replacement pointer that is wrong or not advancing evicts the wrong address. That error appears only on the first request to the evicted address, or to the address that should have been evicted, so the bench probes neighbouring entries straight after each replacement.
- A state machine that leaves the fetch state early, or never leaves it, shows within one cycle of the acknowledge through `busy`, `mem_req` and `done`.

// File: rtl/fa_cache.sv
module fa_cache #(
  parameter int ENTRIES = 16,
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          busy,
  output logic          done,
  output logic          hit,
  output logic [DW-1:0] rd_data,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_data
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [AW-1:0]  tag_q  [ENTRIES];
  logic [DW-1:0]  data_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] match;
  logic [IW-1:0]  match_idx, free_idx, victim, rr_q;
  logic           any_match, any_free, fetching_q;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = valid_q[i] && (tag_q[i] == req_addr);
  end

  always_comb begin
    match_idx = '0;
    any_match = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        match_idx = IW'(i);
        any_match = 1'b1;
      end
    end
  end

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        free_idx = IW'(i);
        any_free = 1'b1;
      end
    end
  end

  assign victim  = any_free ? free_idx : rr_q;
  assign busy    = fetching_q;
  assign mem_req = fetching_q;

  wire accept = req_valid && !fetching_q;
  wire fill   = fetching_q && mem_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetching_q <= 1'b0;
      valid_q    <= '0;
      rr_q       <= '0;
      done       <= 1'b0;
      hit        <= 1'b0;
    end else begin
      done <= 1'b0;
      hit  <= 1'b0;
      if (fill) begin
        fetching_q      <= 1'b0;
        valid_q[victim] <= 1'b1;
        rr_q            <= (rr_q == IW'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        done            <= 1'b1;
      end else if (accept) begin
        if (any_match) begin
          done <= 1'b1;
          hit  <= 1'b1;
        end else begin
          fetching_q <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      tag_q[victim]  <= mem_addr;
      data_q[victim] <= mem_data;
      rd_data        <= mem_data;
    end else if (accept) begin
      if (any_match) rd_data <= data_q[match_idx];
      else           mem_addr <= req_addr;
    end
  end
endmodule

// File: rtl/fa_cache_chk.sv
module fa_cache_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic          busy,
  input logic          done,
  input logic          hit,
  input logic [DW-1:0] rd_data,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic [DW-1:0] mem_data
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R3
  AST_FILL_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> done && !hit && !busy && rd_data == $past(mem_data)); // R4
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done); // R7
  AST_HIT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> done); // R8
  AST_IDLE_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !busy && !done && !mem_req); // R1
endmodule

bind fa_cache fa_cache_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/fa_cache_tb.sv
module fa_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        busy, done, hit, mem_req;
  logic [31:0] rd_data, mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_data = '0;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  fa_cache u_dut (.*);

  function automatic logic [31:0] word_of(input logic [31:0] a);
    return (a * 32'd2654435761) ^ 32'h5A17_C3E1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic issue(input logic [31:0] a);
    req_valid = 1'b1;
    req_addr  = a;
    step();
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    chk(!busy && !done && !hit && !mem_req, "R1 idle after reset",
        {28'd0, busy, done, hit, mem_req}, 32'd0);
  endtask

  task automatic t_hit(input logic [31:0] a, input string req);
    issue(a);
    chk(done && hit && !mem_req, {req, " R2 hit flags"}, {29'd0, done, hit, mem_req}, 32'd6);
    chk(rd_data == word_of(a), {req, " R2 hit data"}, rd_data, word_of(a));
    step();
    chk(!done && !hit, "R8 done single pulse", {30'd0, done, hit}, 32'd0);
  endtask

  task automatic t_miss(input logic [31:0] a, input int wait_cyc, input logic [31:0] stray, input string req);
    issue(a);
    chk(mem_req && busy && !done, {req, " R3 fetch raised"}, {29'd0, mem_req, busy, done}, 32'd6);
    chk(mem_addr == a, {req, " R3 fetch address"}, mem_addr, a);
    for (int i = 0; i < wait_cyc; i++) begin
      if (i == 0 && stray != '0) begin
        req_valid = 1'b1;
        req_addr  = stray;
      end
      step();
      req_valid = 1'b0;
      chk(mem_req && busy && !done && mem_addr == a, "R7 R3 held while waiting", mem_addr, a);
    end
    mem_ack  = 1'b1;
    mem_data = word_of(a);
    step();
    mem_ack  = 1'b0;
    mem_data = '0;
    chk(done && !hit && !busy && !mem_req, "R4 fill return flags",
        {28'd0, done, hit, busy, mem_req}, 32'd8);
    chk(rd_data == word_of(a), "R4 fill data", rd_data, word_of(a));
    step();
    chk(!done, "R8 done single pulse after fill", {31'd0, done}, 32'd0);
  endtask

  function automatic logic [31:0] base_addr(input int i);
    return 32'h0000_1000 + 32'(i) * 32'd4;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_miss(base_addr(0), 3, 32'hDEAD_0000, "R1 first request");
    for (int i = 1; i < 16; i++) t_miss(base_addr(i), i % 4, 32'h0, "R5 warmup fill");
    for (int i = 0; i < 16; i++) t_hit(base_addr(i), "R5 all retained");
    t_miss(32'hDEAD_0000, 2, 32'h0, "R7 stray was ignored");
    t_hit(base_addr(1), "R6 entry1 kept");
    t_hit(32'hDEAD_0000, "R4 installed");
    t_miss(base_addr(0), 1, 32'h0, "R6 entry0 evicted");
    t_miss(base_addr(1), 0, 32'h0, "R6 entry1 evicted next");
    t_hit(base_addr(3), "R6 entry3 kept");
    t_hit(base_addr(0), "R6 refill retained");
    t_reset();
    t_miss(base_addr(3), 0, 32'h0, "R1 cleared by reset");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule